// File: doc/BRIEF.md
# Programmable Phase Sequencer for a Serial Memory Controller

This block runs short stored programs that describe how a transaction to an external serial memory is built up, one phase at a time. Software fills a table of 64 words of 32 bits. Each word holds two 16-bit instructions. The table is split into eight programs of sixteen instructions each. Writing a program number to the start port launches that program. The sequencer then walks through the instructions and hands every phase to a downstream serializer. A phase is a command byte, an address, dummy cycles, a read or a write. Each phase goes out on a valid/ready channel that carries the phase kind, the lane count, a double-data-rate flag, the operand and the selected device.

Programs may jump to the start of another program or to another instruction within the same program. A program ends at a stop instruction, at any undefined opcode, or after its sixteenth instruction. Software can lock the table against edits. The phase channel follows valid/ready rules. Once `ph_valid` is high, it stays high and every field stays stable until the cycle in which `ph_ready` is sampled high. That cycle is the done handshake for the phase, and the sequencer moves on at the same clock edge. The sequencer can be held back for any number of cycles.

Top module: `lut_phase_sequencer`

## Requirements
- R1: Instruction index i of program p is taken from table word p*8 + i/2. Even i uses bits 15:0 of that word and odd i uses bits 31:16. Within an instruction, bits 15:10 are the opcode, bits 9:8 are the lane code and bits 7:0 are the operand. The operand is presented unchanged on `ph_operand`.
- R2: Phase opcodes map to `ph_kind` as follows: 0x01 and 0x11 give 0 (command), 0x02 and 0x12 give 1 (extended command), 0x03 and 0x13 give 2 (address), 0x10 gives 3 (dummy), 0x04 and 0x14 give 4 (write), and 0x05 and 0x15 give 5 (read). `ph_ddr` is 1 only for 0x11 to 0x15. `ph_width` repeats the lane code, where 0, 1, 2 and 3 mean 1, 2, 4 and 8 lines.
- R3: While `ph_valid` is high and `ph_ready` is low, `ph_valid` and every phase field stay unchanged in the next cycle. When `ph_ready` is high, the next instruction is fetched.
- R4: Opcode 0x00 and every opcode that is not defined here end the program without a phase. `busy` falls one cycle after such an instruction is reached. `ph_valid` is never high while `busy` is low.
- R5: After the phase at instruction 15 of a program is accepted, the program ends even if no stop instruction follows.
- R6: Opcode 0x20 continues at instruction 0 of the program given by operand bits 2:0. Opcode 0x30 continues at the instruction given by operand bits 3:0 within the current program. Neither one emits a phase.
- R7: A start write while idle sets `busy` at the next clock edge and runs the selected program from instruction 0. A start write while busy is ignored.
- R8: `dev_sel` is captured at the start write and reported on `ph_dev` for every phase of that run.
- R9: After reset the table is unlocked. A lock write of 1 locks it, a write of 2 unlocks it, and other values are ignored. While the table is locked, table writes leave the contents unchanged.
- R10: An update write of 1 locks the table, which commits the edits. Other update values have no effect. If a lock write and an update write arrive in the same cycle, the lock write wins.
- R11: Reset clears `busy` and `ph_valid`, and sets every table word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lut_wr_en | input | 1 | Table word write strobe |
| lut_wr_addr | input | 6 | Table word address |
| lut_wr_data | input | 32 | Table word value |
| lut_rd_addr | input | 6 | Read-back address |
| lut_rd_data | output | 32 | Read-back word |
| lock_wr_en | input | 1 | Lock register write strobe |
| lock_wr_data | input | 2 | 1 = lock, 2 = unlock |
| upd_wr_en | input | 1 | Update register write strobe |
| upd_wr_data | input | 2 | 1 = commit and lock |
| start_wr_en | input | 1 | Start register write strobe |
| start_id | input | 3 | Program number to run |
| dev_sel | input | 1 | Device select captured at start |
| busy | output | 1 | A program is running |
| locked | output | 1 | Table is write protected |
| ph_valid | output | 1 | Phase request valid |
| ph_ready | input | 1 | Phase done / accepted |
| ph_kind | output | 3 | Phase kind code |
| ph_width | output | 2 | Lane code |
| ph_ddr | output | 1 | Double data rate phase |
| ph_operand | output | 8 | Phase operand |
| ph_dev | output | 1 | Device for this phase |

## Verification
All 64 opcode values are placed in the first slot of one program, with lane codes that rotate. This separates phases from stops, undefined codes and both jump forms, and it shows whether each jump lands at its target. Further programs test ordering and termination: one fills all sixteen slots with distinct operands, which exposes swapped halves and a missing end-of-region stop, and another chains a program jump with an instruction jump. Runs use back-pressure delays of zero to two cycles, both device selects, and a start write issued mid-run. The lock, unlock and update codes are each checked through table read-back after an attempted write.

// File: rtl/lut_seq_pkg.sv
package lut_seq_pkg;
  localparam int INS_W = 16;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] lanes;
    logic [7:0] arg;
  } ins_t;

  typedef enum logic [2:0] {
    PK_CMD = 3'd0, PK_CMDX = 3'd1, PK_ADDR = 3'd2,
    PK_DUMMY = 3'd3, PK_WRITE = 3'd4, PK_READ = 3'd5
  } phase_kind_e;

  typedef enum logic [1:0] {ACT_END, ACT_PHASE, ACT_JID, ACT_JINS} act_e;

  localparam logic [5:0] OP_DUMMY = 6'h10;
  localparam logic [5:0] OP_JID   = 6'h20;
  localparam logic [5:0] OP_JINS  = 6'h30;
endpackage

// File: rtl/lut_store.sv
module lut_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lock_wr_en,
  input  logic [1:0]        lock_wr_data,
  input  logic              upd_wr_en,
  input  logic [1:0]        upd_wr_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] fetch_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              locked
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && !lock_q) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // lock register: explicit lock/unlock codes outrank the update strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               lock_q <= 1'b0;
    else if (lock_wr_en && lock_wr_data == 2'd1) lock_q <= 1'b1;
    else if (lock_wr_en && lock_wr_data == 2'd2) lock_q <= 1'b0;
    else if (upd_wr_en && upd_wr_data == 2'd1)   lock_q <= 1'b1;
  end

  assign fetch_data = mem[fetch_addr];
  assign rd_data    = mem[rd_addr];
  assign locked     = lock_q;
endmodule

// File: rtl/op_decode.sv
module op_decode
  import lut_seq_pkg::*;
(
  input  ins_t        ins,
  output act_e        act,
  output phase_kind_e kind,
  output logic        ddr
);
  always_comb begin
    act  = ACT_END;
    kind = PK_CMD;
    ddr  = 1'b0;
    if (ins.op == OP_DUMMY) begin
      act  = ACT_PHASE;
      kind = PK_DUMMY;
    end else if (ins.op == OP_JID) begin
      act = ACT_JID;
    end else if (ins.op == OP_JINS) begin
      act = ACT_JINS;
    end else if (ins.op[5] == 1'b0 && ins.op[3] == 1'b0 &&
                 ins.op[2:0] >= 3'd1 && ins.op[2:0] <= 3'd5) begin
      act = ACT_PHASE;
      ddr = ins.op[4];
      unique case (ins.op[2:0])
        3'd1:    kind = PK_CMD;
        3'd2:    kind = PK_CMDX;
        3'd3:    kind = PK_ADDR;
        3'd4:    kind = PK_WRITE;
        default: kind = PK_READ;
      endcase
    end
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import lut_seq_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr_en,
  input  logic [ID_W-1:0]  start_id,
  input  logic             dev_sel,
  input  act_e             act,
  input  logic [7:0]       arg,
  input  logic             ph_ready,
  output logic [ID_W-1:0]  cur_id,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy,
  output logic             ph_valid,
  output logic             ph_dev
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

  logic             busy_q, dev_q;
  logic [ID_W-1:0]  id_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dev_q  <= 1'b0;
      id_q   <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_wr_en) begin
        busy_q <= 1'b1;
        id_q   <= start_id;
        idx_q  <= '0;
        dev_q  <= dev_sel;
      end
    end else begin
      unique case (act)
        ACT_PHASE: if (ph_ready) begin
          if (idx_q == LAST_IDX) busy_q <= 1'b0;
          else                   idx_q  <= idx_q + 1'b1;
        end
        ACT_JID: begin
          id_q  <= arg[ID_W-1:0];
          idx_q <= '0;
        end
        ACT_JINS: idx_q  <= arg[IDX_W-1:0];
        default:  busy_q <= 1'b0;
      endcase
    end
  end

  assign cur_id   = id_q;
  assign cur_idx  = idx_q;
  assign busy     = busy_q;
  assign ph_valid = busy_q && (act == ACT_PHASE);
  assign ph_dev   = dev_q;
endmodule

// File: rtl/lut_phase_sequencer.sv
module lut_phase_sequencer
  import lut_seq_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int IDX_W = 4,
  localparam int ADDR_W = ID_W + IDX_W - 1,
  localparam int WORD_W = 2 * INS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lut_wr_en,
  input  logic [ADDR_W-1:0] lut_wr_addr,
  input  logic [WORD_W-1:0] lut_wr_data,
  input  logic [ADDR_W-1:0] lut_rd_addr,
  output logic [WORD_W-1:0] lut_rd_data,
  input  logic              lock_wr_en,
  input  logic [1:0]        lock_wr_data,
  input  logic              upd_wr_en,
  input  logic [1:0]        upd_wr_data,
  input  logic              start_wr_en,
  input  logic [ID_W-1:0]   start_id,
  input  logic              dev_sel,
  output logic              busy,
  output logic              locked,
  output logic              ph_valid,
  input  logic              ph_ready,
  output logic [2:0]        ph_kind,
  output logic [1:0]        ph_width,
  output logic              ph_ddr,
  output logic [7:0]        ph_operand,
  output logic              ph_dev
);
  logic [ID_W-1:0]   cur_id;
  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] word;
  ins_t              ins;
  act_e              act;
  phase_kind_e       kind;

  lut_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lut_wr_en), .wr_addr(lut_wr_addr), .wr_data(lut_wr_data),
    .lock_wr_en(lock_wr_en), .lock_wr_data(lock_wr_data),
    .upd_wr_en(upd_wr_en), .upd_wr_data(upd_wr_data),
    .fetch_addr({cur_id, cur_idx[IDX_W-1:1]}), .fetch_data(word),
    .rd_addr(lut_rd_addr), .rd_data(lut_rd_data), .locked(locked)
  );

  // even slot in the low half, odd slot in the high half
  assign ins = cur_idx[0] ? ins_t'(word[WORD_W-1:INS_W]) : ins_t'(word[INS_W-1:0]);

  op_decode u_dec (.ins(ins), .act(act), .kind(kind), .ddr(ph_ddr));

  seq_core #(.ID_W(ID_W), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start_wr_en(start_wr_en), .start_id(start_id), .dev_sel(dev_sel),
    .act(act), .arg(ins.arg), .ph_ready(ph_ready),
    .cur_id(cur_id), .cur_idx(cur_idx),
    .busy(busy), .ph_valid(ph_valid), .ph_dev(ph_dev)
  );

  assign ph_kind    = kind;
  assign ph_width   = ins.lanes;
  assign ph_operand = ins.arg;
endmodule

// File: rtl/lut_phase_sequencer_chk.sv
module lut_phase_sequencer_chk #(
  parameter int ID_W  = 3,
  parameter int IDX_W = 4,
  localparam int ADDR_W = ID_W + IDX_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lut_wr_en,
  input logic [ADDR_W-1:0] lut_rd_addr,
  input logic [31:0]       lut_rd_data,
  input logic              lock_wr_en,
  input logic [1:0]        lock_wr_data,
  input logic              upd_wr_en,
  input logic [1:0]        upd_wr_data,
  input logic              start_wr_en,
  input logic              busy,
  input logic              locked,
  input logic              ph_valid,
  input logic              ph_ready,
  input logic [2:0]        ph_kind,
  input logic [1:0]        ph_width,
  input logic              ph_ddr,
  input logic [7:0]        ph_operand,
  input logic              ph_dev
);
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid && !ph_ready |=> ph_valid && $stable(ph_kind) && $stable(ph_width)
                              && $stable(ph_ddr) && $stable(ph_operand));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ph_valid);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr_en && !busy |=> busy);
  // R8
  dev_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ph_dev));
  // R9
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr_en && lock_wr_data == 2'd1 |=> locked);
  // R9
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && lut_wr_en |=> (lut_rd_addr != $past(lut_rd_addr)) || $stable(lut_rd_data));
  // R10
  upd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_wr_en && upd_wr_data == 2'd1 && !lock_wr_en |=> locked);
endmodule

bind lut_phase_sequencer lut_phase_sequencer_chk u_chk (.*);

// File: tb/test_lut_phase_sequencer.sv
module test_lut_phase_sequencer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lut_wr_en = 0, lock_wr_en = 0, upd_wr_en = 0, start_wr_en = 0;
  logic [5:0]  lut_wr_addr = 0, lut_rd_addr = 0;
  logic [31:0] lut_wr_data = 0, lut_rd_data;
  logic [1:0]  lock_wr_data = 0, upd_wr_data = 0;
  logic [2:0]  start_id = 0;
  logic        dev_sel = 0, ph_ready = 0;
  logic        busy, locked, ph_valid, ph_ddr, ph_dev;
  logic [2:0]  ph_kind;
  logic [1:0]  ph_width;
  logic [7:0]  ph_operand;

  int total = 0, bad = 0, dly = 0;
  logic [31:0] sh [64];

  always #5 clk = ~clk;

  lut_phase_sequencer i_lut_phase_sequencer (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [15:0] mk(input int op, input int ln, input int arg);
    return {6'(op), 2'(ln), 8'(arg)};
  endfunction

  function automatic bit is_phase(input int op);
    return (op >= 1 && op <= 5) || (op >= 17 && op <= 21) || op == 16;
  endfunction

  function automatic int exp_kind(input int op);
    if (op == 16) return 3;
    case (op % 8)
      1: return 0; 2: return 1; 3: return 2; 4: return 4; default: return 5;
    endcase
  endfunction

  task automatic wr_lut(input int a, input logic [31:0] d, input bit take);
    @(negedge clk);
    lut_wr_en = 1; lut_wr_addr = 6'(a); lut_wr_data = d;
    @(negedge clk);
    lut_wr_en = 0;
    if (take) sh[a] = d;
  endtask

  task automatic put(input int id, input int idx, input logic [15:0] ins);
    logic [31:0] w;
    w = sh[id*8 + idx/2];
    if (idx % 2 == 1) w[31:16] = ins; else w[15:0] = ins;
    wr_lut(id*8 + idx/2, w, 1);
  endtask

  task automatic lock_wr(input int v);
    @(negedge clk); lock_wr_en = 1; lock_wr_data = 2'(v);
    @(negedge clk); lock_wr_en = 0;
  endtask

  task automatic upd_wr(input int v);
    @(negedge clk); upd_wr_en = 1; upd_wr_data = 2'(v);
    @(negedge clk); upd_wr_en = 0;
  endtask

  // walk the bench's own copy of the table to the next phase instruction
  task automatic next_phase(inout int eid, inout int eidx, output bit found, output logic [15:0] ins);
    found = 0; ins = 0;
    for (int s = 0; s < 40; s++) begin
      logic [31:0] w;
      int op;
      w = sh[eid*8 + eidx/2];
      ins = (eidx % 2 == 1) ? w[31:16] : w[15:0];
      op = int'(ins[15:10]);
      if (is_phase(op)) begin found = 1; return; end
      else if (op == 32) begin eid = int'(ins[2:0]); eidx = 0; end
      else if (op == 48) eidx = int'(ins[3:0]);
      else return;
    end
  endtask

  task automatic run_seq(input int id, input bit dev, input bit interfere);
    int eid = id, eidx = 0, w, op, d;
    bit found;
    logic [15:0] ins;
    @(negedge clk);
    start_wr_en = 1; start_id = 3'(id); dev_sel = dev;
    @(negedge clk);
    start_wr_en = 0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    forever begin
      if (eidx > 15) found = 0;
      else next_phase(eid, eidx, found, ins);
      if (!found) begin
        w = 0;
        while (busy && w < 60) begin @(negedge clk); w++; end
        chk(!busy && !ph_valid, "R4/R5 program end", {busy, ph_valid}, 0);
        return;
      end
      w = 0;
      while (!ph_valid && w < 60) begin @(negedge clk); w++; end
      op = int'(ins[15:10]);
      chk(ph_valid, "R3 phase presented", ph_valid, 1);
      chk(ph_kind == 3'(exp_kind(op)) && ph_width == ins[9:8] &&
          ph_ddr == (op >= 17 && op <= 21), "R2 phase decode",
          {ph_kind, ph_width, ph_ddr}, {3'(exp_kind(op)), ins[9:8], 1'(op >= 17 && op <= 21)});
      chk(ph_operand == ins[7:0], "R1 operand/order", ph_operand, ins[7:0]);
      chk(ph_dev == dev, "R8 device", ph_dev, dev);
      d = dly % 3; dly++;
      for (int k = 0; k < d; k++) begin
        if (interfere && k == 0) begin start_wr_en = 1; start_id = 3'(id ^ 7); dev_sel = !dev; end
        @(negedge clk);
        start_wr_en = 0;
        chk(ph_valid && ph_operand == ins[7:0], "R3 hold under back-pressure", ph_operand, ins[7:0]);
      end
      ph_ready = 1;
      @(negedge clk);
      ph_ready = 0;
      eidx++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int zbad;
    for (int i = 0; i < 64; i++) sh[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !ph_valid && !locked, "R11 reset outputs", {busy, ph_valid, locked}, 0);
    zbad = 0;
    for (int a = 0; a < 64; a++) begin
      lut_rd_addr = 6'(a); #1;
      if (lut_rd_data != 0) zbad++;
    end
    chk(zbad == 0, "R11 table cleared", zbad, 0);

    // R4 empty program (all stop)
    run_seq(5, 0, 0);

    // R5 all sixteen slots are phases
    for (int i = 0; i < 16; i++)
      put(2, i, mk((i % 2 == 0) ? 1 + (i % 5) : 17 + (i % 5), i % 4, 8'h20 + i));
    run_seq(2, 0, 0);
    run_seq(2, 1, 0);

    // R6 jump chain: program 3 -> program 4 -> slot 5
    put(3, 0, mk(1, 3, 8'h33));
    put(3, 1, mk(32, 0, 4));
    put(4, 0, mk(48, 0, 5));
    put(4, 1, mk(1, 0, 8'hEE));
    put(4, 5, mk(21, 2, 8'h10));
    put(4, 6, mk(16, 1, 8'h08));
    run_seq(3, 1, 0);

    // R7 start while busy must be ignored
    put(7, 0, mk(1, 0, 8'h77));
    run_seq(2, 0, 1);

    // R1 R2 R4 R6 opcode sweep in program 1 slot 0
    put(6, 0, mk(1, 1, 8'hA6));
    put(1, 6, mk(2, 2, 8'hB1));
    put(1, 1, mk(3, 3, 8'hC1));
    for (int op = 0; op < 64; op++) begin
      put(1, 0, mk(op, op % 4, 8'h06));
      run_seq(1, op % 2, 0);
    end

    // R9 lock behaviour
    lut_rd_addr = 6'd63;
    lock_wr(1);
    chk(locked, "R9 lock code 1", locked, 1);
    wr_lut(63, 32'hDEAD_BEEF, 0);
    chk(lut_rd_data == sh[63], "R9 write ignored while locked", lut_rd_data, sh[63]);
    lock_wr(3);
    chk(locked, "R9 code 3 ignored", locked, 1);
    lock_wr(2);
    chk(!locked, "R9 unlock code 2", locked, 0);
    wr_lut(63, 32'h1234_5678, 1);
    chk(lut_rd_data == 32'h1234_5678, "R9 write while unlocked", lut_rd_data, 32'h1234_5678);
    // R10 update strobe
    upd_wr(2);
    chk(!locked, "R10 update code 2 ignored", locked, 0);
    upd_wr(1);
    chk(locked, "R10 update code 1 locks", locked, 1);
    wr_lut(63, 32'h0, 0);
    chk(lut_rd_data == 32'h1234_5678, "R10 edits committed", lut_rd_data, 32'h1234_5678);
    @(negedge clk);
    lock_wr_en = 1; lock_wr_data = 2'd2; upd_wr_en = 1; upd_wr_data = 2'd1;
    @(negedge clk);
    lock_wr_en = 0; upd_wr_en = 0;
    chk(!locked, "R10 lock write outranks update", locked, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule